// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer Unit

This block is a timer unit for a processor. It keeps a 64-bit free-running time base and a 32-bit down-counter. Both advance on the same tick-enable input. When the down-counter steps from one to zero it raises a decrementer event. It can also replace that zero with a programmed reload value in the same cycle, so the counter runs as a periodic timer.

Software reaches every register through a register port. The port has a write strobe, an address and write data, and a combinational read-back. The event is latched in a status bit that software clears by writing 1. An interrupt request is raised while that bit is set and interrupts are enabled.

Register addresses are: 0 time base low half, 1 time base high half, 2 down-counter, 3 reload value, 4 control, 5 status.

Top module: `dec_timer_unit`

## Requirements
- R1: After an active-low reset, the following all read zero and `irq_o` is low: both time-base halves, the down-counter, the reload value, control and status.
- R2: The time-base halves at address 0 (low) and address 1 (high) can each be written and read on their own. A write to either half takes priority over a tick in the same cycle.
- R3: Each cycle with `tick_i` high, and no time-base write, adds one to the 64-bit value {high, low`}`. A low half of 0xFFFF_FFFF wraps to zero and carries into the high half.
- R4: Each cycle with `tick_i` high, a down-counter above one, and no counter write, reduces the counter by one.
- R5: Control bit 0 enables reload. When it is set and a tick moves the counter from 1 to 0, the counter takes the reload value (address 3) instead of zero. The status bit 0 is set.
- R6: With reload disabled, a tick from 1 gives zero and sets status bit 0. From then on the counter stays at zero under further ticks and never wraps to 0xFFFF_FFFF.
- R7: A software write to the down-counter never sets status bit 0. This holds for a write of zero and for a write in the same cycle as a tick. In a same-cycle write and tick, the written value is kept.
- R8: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. If the event sets the bit in the same cycle as a write-1 clear, the bit ends set.
- R9: `irq_o` is high exactly while status bit 0 is set and control bit 1 (interrupt enable) is set.
- R10: In cycles without `tick_i` and without writes, the time base and the down-counter keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | Advances the time base and the down-counter |
| irq_o | output | 1 | Decrementer interrupt request |

## Verification
A write or a tick at one rising edge shows up on `rdata_o` one edge later. The read mux is combinational, so the bench drives the address at the falling edge and samples it shortly after. The decrementer status bit and `irq_o` sit one register behind the tick that moves the counter from 1 to 0. The bench therefore reads status, and samples `irq_o`, at the falling edge right after that tick edge. Cases that share a cycle use one edge each, and the result is checked at the following falling edge. These are a write together with a tick, and an event together with a clear.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 3;
  localparam int unsigned CTL_W  = 2;
  localparam int unsigned CTL_RLD = 0;
  localparam int unsigned CTL_IEN = 1;

  typedef enum logic [AW-1:0] {
    REG_TB_LO  = 3'd0,
    REG_TB_HI  = 3'd1,
    REG_CNT    = 3'd2,
    REG_RELOAD = 3'd3,
    REG_CTRL   = 3'd4,
    REG_STATUS = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/dtu_time_base.sv
module dtu_time_base #(
  parameter int unsigned HW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wdata_i,
  output logic [HW-1:0] lo_o,
  output logic [HW-1:0] hi_o
);
  localparam int unsigned TW = 2 * HW;

  logic [TW-1:0] tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // software write wins over a tick on either half
      if (wr_lo_i) tb_q[HW-1:0]  <= wdata_i;
      if (wr_hi_i) tb_q[TW-1:HW] <= wdata_i;
    end else if (tick_i) begin
      tb_q <= tb_q + TW'(1);
    end
  end

  assign lo_o = tb_q[HW-1:0];
  assign hi_o = tb_q[TW-1:HW];
endmodule

// File: rtl/dtu_down_counter.sv
module dtu_down_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_cnt_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wdata_i,
  input  logic         reload_en_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] reload_o,
  output logic         zero_evt_o
);
  logic [W-1:0] cnt_q, rld_q;
  logic         at_one, at_zero;

  assign at_one  = (cnt_q == W'(1));
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
    end else if (wr_rld_i) begin
      rld_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (tick_i && !at_zero) begin
      cnt_q <= (at_one && reload_en_i) ? rld_q : cnt_q - W'(1);
    end
  end

  // only a counted step 1 -> 0 is an event, never a write
  assign zero_evt_o = tick_i && !wr_cnt_i && at_one;
  assign cnt_o      = cnt_q;
  assign reload_o   = rld_q;
endmodule

// File: rtl/dtu_status.sv
module dtu_status #(
  parameter int unsigned NEV = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic           wr_i,
  input  logic [NEV-1:0] wdata_i,
  output logic [NEV-1:0] st_o
);
  logic [NEV-1:0] st_q;

  for (genvar g = 0; g < NEV; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q[g] <= 1'b0;
      else if (set_i[g]) st_q[g] <= 1'b1;  // set beats clear
      else if (wr_i && wdata_i[g]) st_q[g] <= 1'b0;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/dec_timer_unit.sv
module dec_timer_unit
  import dtu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic          irq_o
);
  logic [DW-1:0]    tb_lo, tb_hi, cnt_val, reload_val;
  logic [CTL_W-1:0] ctl_q;
  logic [0:0]       st_val;
  logic             zero_evt;
  logic             wr_lo, wr_hi, wr_cnt, wr_rld, wr_ctl, wr_st;

  assign wr_lo  = wr_en_i && (addr_i == REG_TB_LO);
  assign wr_hi  = wr_en_i && (addr_i == REG_TB_HI);
  assign wr_cnt = wr_en_i && (addr_i == REG_CNT);
  assign wr_rld = wr_en_i && (addr_i == REG_RELOAD);
  assign wr_ctl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_st  = wr_en_i && (addr_i == REG_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata_i[CTL_W-1:0];
  end

  dtu_time_base #(.HW(DW)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wdata_i),
    .lo_o    (tb_lo),
    .hi_o    (tb_hi)
  );

  dtu_down_counter #(.W(DW)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .wr_cnt_i    (wr_cnt),
    .wr_rld_i    (wr_rld),
    .wdata_i     (wdata_i),
    .reload_en_i (ctl_q[CTL_RLD]),
    .cnt_o       (cnt_val),
    .reload_o    (reload_val),
    .zero_evt_o  (zero_evt)
  );

  dtu_status #(.NEV(1)) u_st (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (zero_evt),
    .wr_i    (wr_st),
    .wdata_i (wdata_i[0]),
    .st_o    (st_val)
  );

  always_comb begin
    unique case (addr_i)
      REG_TB_LO:  rdata_o = tb_lo;
      REG_TB_HI:  rdata_o = tb_hi;
      REG_CNT:    rdata_o = cnt_val;
      REG_RELOAD: rdata_o = reload_val;
      REG_CTRL:   rdata_o = DW'(ctl_q);
      REG_STATUS: rdata_o = DW'(st_val);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = st_val[0] && ctl_q[CTL_IEN];
endmodule

// File: rtl/dtu_chk.sv
module dtu_chk
  import dtu_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic          tick_i,
  input logic          irq_o,
  input logic [DW-1:0] tb_lo,
  input logic [DW-1:0] tb_hi,
  input logic [DW-1:0] cnt_val,
  input logic [DW-1:0] reload_val,
  input logic [CTL_W-1:0] ctl_q,
  input logic [0:0]    st_val
);
  logic wr_cnt, wr_tb;
  assign wr_cnt = wr_en_i && (addr_i == REG_CNT);
  assign wr_tb  = wr_en_i && ((addr_i == REG_TB_LO) || (addr_i == REG_TB_HI));

  // R3
  tb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_tb) |=> {tb_hi, tb_lo} == $past({tb_hi, tb_lo}) + 64'd1);

  // R10
  tb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_tb) |=> $stable({tb_hi, tb_lo}));

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && cnt_val > 32'd1) |=> cnt_val == $past(cnt_val) - 32'd1);

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && cnt_val == 32'd1 && ctl_q[CTL_RLD])
      |=> cnt_val == $past(reload_val));

  // R6
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_cnt && cnt_val == '0) |=> cnt_val == '0);

  // R7
  sw_write_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && !st_val[0]) |=> !st_val[0]);

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && cnt_val == 32'd1) |=> st_val[0]);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st_val[0] && ctl_q[CTL_IEN]));
endmodule

bind dec_timer_unit dtu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .tick_i     (tick_i),
  .irq_o      (irq_o),
  .tb_lo      (tb_lo),
  .tb_hi      (tb_hi),
  .cnt_val    (cnt_val),
  .reload_val (reload_val),
  .ctl_q      (ctl_q),
  .st_val     (st_val)
);

// File: tb/dec_timer_unit_test.sv
module dec_timer_unit_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2, K_WT = 2'd3;
  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_CNT = 3'd2,
                         A_RLD = 3'd3, A_CTL = 3'd4, A_ST = 3'd5;
  localparam int NV = 46;
  // {kind, addr, data, expected, requirement}
  localparam logic [72:0] VEC [NV] = '{
    {K_RD, A_LO,  32'h0, 32'h0, 4'd1},          // R1
    {K_RD, A_HI,  32'h0, 32'h0, 4'd1},
    {K_RD, A_CNT, 32'h0, 32'h0, 4'd1},
    {K_RD, A_RLD, 32'h0, 32'h0, 4'd1},
    {K_RD, A_CTL, 32'h0, 32'h0, 4'd1},
    {K_RD, A_ST,  32'h0, 32'h0, 4'd1},
    {K_WR, A_LO,  32'hFFFF_FFFE, 32'h0, 4'd2},  // R2
    {K_WR, A_HI,  32'h5, 32'h0, 4'd2},
    {K_RD, A_LO,  32'h0, 32'hFFFF_FFFE, 4'd2},
    {K_RD, A_HI,  32'h0, 32'h5, 4'd2},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd3},          // R3 carry
    {K_RD, A_LO,  32'h0, 32'hFFFF_FFFF, 4'd3},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd3},
    {K_RD, A_LO,  32'h0, 32'h0, 4'd3},
    {K_RD, A_HI,  32'h0, 32'h6, 4'd3},
    {K_WT, A_LO,  32'h100, 32'h0, 4'd2},        // R2 write beats tick
    {K_RD, A_LO,  32'h0, 32'h100, 4'd2},
    {K_WR, A_CNT, 32'h3, 32'h0, 4'd4},          // R4
    {K_TK, A_LO,  32'h0, 32'h0, 4'd4},
    {K_RD, A_CNT, 32'h0, 32'h2, 4'd4},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd4},
    {K_RD, A_CNT, 32'h0, 32'h1, 4'd4},
    {K_RD, A_ST,  32'h0, 32'h0, 4'd6},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd6},          // R6
    {K_RD, A_CNT, 32'h0, 32'h0, 4'd6},
    {K_RD, A_ST,  32'h0, 32'h1, 4'd6},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd6},
    {K_RD, A_CNT, 32'h0, 32'h0, 4'd6},
    {K_WR, A_ST,  32'h0, 32'h0, 4'd8},          // R8
    {K_RD, A_ST,  32'h0, 32'h1, 4'd8},
    {K_WR, A_ST,  32'h1, 32'h0, 4'd8},
    {K_RD, A_ST,  32'h0, 32'h0, 4'd8},
    {K_WR, A_RLD, 32'h10, 32'h0, 4'd5},         // R5
    {K_WR, A_CTL, 32'h1, 32'h0, 4'd5},
    {K_WR, A_CNT, 32'h1, 32'h0, 4'd5},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd5},
    {K_RD, A_CNT, 32'h0, 32'h10, 4'd5},
    {K_RD, A_ST,  32'h0, 32'h1, 4'd5},
    {K_WR, A_ST,  32'h1, 32'h0, 4'd7},          // R7
    {K_WR, A_CNT, 32'h0, 32'h0, 4'd7},
    {K_TK, A_LO,  32'h0, 32'h0, 4'd7},
    {K_RD, A_ST,  32'h0, 32'h0, 4'd7},
    {K_RD, A_CNT, 32'h0, 32'h0, 4'd7},
    {K_WT, A_CNT, 32'h1, 32'h0, 4'd7},
    {K_RD, A_CNT, 32'h0, 32'h1, 4'd7},
    {K_RD, A_ST,  32'h0, 32'h0, 4'd7}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_i = 1'b0;
  logic        irq_o;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dec_timer_unit uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .tick_i  (tick_i),
    .irq_o   (irq_o)
  );

  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
    @(negedge clk_i);
    wr_en_i = w; addr_i = a; wdata_i = d; tick_i = t;
    @(posedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0; addr_i = a;
    #1;
    checks++;
    if (rdata_o !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata_o, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
    #1;
    checks++;
    if (irq_o !== exp) begin
      fails++;
      $display("FAIL %s irq_o: got %b expected %b", req, irq_o, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      case (v[72:71])
        K_WR: cyc(1'b1, v[70:68], v[67:36], 1'b0);
        K_TK: cyc(1'b0, v[70:68], 32'h0, 1'b1);
        K_WT: cyc(1'b1, v[70:68], v[67:36], 1'b1);
        default: rd(v[70:68], v[35:4], $sformatf("R%0d", v[3:0]));
      endcase
    end
    // R9 interrupt gating
    cyc(1'b1, A_CTL, 32'h3, 1'b0);
    cyc(1'b1, A_CNT, 32'h1, 1'b0);
    chk_irq(1'b0, "R9");
    cyc(1'b0, A_LO, 32'h0, 1'b1);
    chk_irq(1'b1, "R9");
    cyc(1'b1, A_CTL, 32'h1, 1'b0);
    chk_irq(1'b0, "R9");
    cyc(1'b1, A_CTL, 32'h3, 1'b0);
    chk_irq(1'b1, "R9");
    cyc(1'b1, A_ST, 32'h1, 1'b0);
    chk_irq(1'b0, "R9");
    // R8 set beats clear in the same cycle
    cyc(1'b1, A_CNT, 32'h1, 1'b0);
    cyc(1'b1, A_ST, 32'h1, 1'b1);
    rd(A_ST, 32'h1, "R8");
    // R10 idle cycles hold state
    cyc(1'b1, A_CNT, 32'h7, 1'b0);
    cyc(1'b1, A_LO, 32'h55, 1'b0);
    repeat (4) cyc(1'b0, A_LO, 32'h0, 1'b0);
    rd(A_CNT, 32'h7, "R10");
    rd(A_LO, 32'h55, "R10");
    // R1 reset in mid run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    checks++;
    if (irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 irq_o: got %b expected 0", irq_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(A_CNT, 32'h0, "R1");
    rd(A_LO, 32'h0, "R1");
    rd(A_ST, 32'h0, "R1");
    rd(A_CTL, 32'h0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule